// File: doc/BRIEF.md
# Triggered Waveform Capture

The block records several sample streams at once into per-channel ring buffers and freezes them around a selected trigger event. A programmed number of samples from before the trigger and from after it are kept, so a captured record shows both the lead-up and the aftermath. Uses include post-mortem capture on an interlock trip and timing checks of a setpoint ramp. Each capture channel carries a selector that picks what it records: its own raw ADC lane, the cavity vector sum, the loop error or the amplifier drive.

Outside periodic mode, a capture starts with an arm pulse. Any edge from the chosen source is ignored until enough history has built up. Once the post-trigger count has been written, writing stops and a done flag rises. The buffer position of the trigger sample is latched. A read port takes a record index and returns samples oldest first. In periodic mode an internal rate timer re-arms and triggers the capture on its own, so no acknowledge is needed. The buffer depth is a parameter: the default is kept small, and a deployment sets it to 16384.

Top module: `wavecap_top`

## Requirements
- R1: After reset, `done_o` is 0, `trig_addr_o` is 0 and `rd_data_o` is 0.
- R2: `trig_sel_i` picks the trigger: 0 periodic timer, 1 interlock trip, 2 external input 0, 3 external input 1, 4 ramp start. Events from sources that are not selected have no effect.
- R3: Trigger inputs act on their rising edge only. A level held high across a re-arm does not start a second capture.
- R4: A trigger is ignored until at least `pre_i` samples have been written since arming.
- R5: Record index k (0 = oldest) returns the sample written k−`pre_i` samples relative to the trigger sample. Index `pre_i` is the trigger sample. The record holds `pre_i`+`post_i` samples, which stays valid across buffer wrap when the sum is at most DEPTH.
- R6: The trigger sample counts as the first of `post_i` post-trigger samples (0 is treated as 1). `done_o` rises `post_i` cycles after the trigger cycle, and no further writes occur while done.
- R7: `trig_addr_o` holds the buffer address of the trigger sample, counted from address 0 at the first write after arming, and stays stable while done.
- R8: Channel c's two-bit field `src_sel_i[2c+1:2c]` selects 0 its own ADC lane, 1 vector sum, 2 loop error, 3 drive.
- R9: Outside periodic mode, arm pulses and triggers are ignored while done, until `ack_i` returns the block to idle.
- R10: In periodic mode, every RATE_CYC cycles a timer tick arms an idle or done block and triggers an armed one, so captures repeat without any acknowledge.
- R11: Read data appears one clock after `rd_ch_i`/`rd_idx_i` are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one sample per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start a capture from idle |
| ack_i | input | 1 | Acknowledge a finished capture |
| trig_sel_i | input | 3 | Trigger source code |
| ilk_trip_i | input | 1 | Interlock trip, active high |
| ext0_i | input | 1 | External trigger 0 |
| ext1_i | input | 1 | External trigger 1 |
| ramp_i | input | 1 | Ramp start event |
| pre_i | input | ADDR_W+1 | Pre-trigger sample count |
| post_i | input | ADDR_W+1 | Post-trigger sample count, trigger included |
| src_sel_i | input | 2*NUM_CH | Per-channel source selectors |
| adc_i | input | NUM_CH*DATA_W | Raw ADC lanes, one per channel |
| sum_i | input | DATA_W | Cavity vector sum |
| err_i | input | DATA_W | Loop error |
| drv_i | input | DATA_W | Amplifier drive |
| rd_ch_i | input | CH_W | Channel to read |
| rd_idx_i | input | ADDR_W | Record index, 0 = oldest |
| rd_data_o | output | DATA_W | Registered read data |
| done_o | output | 1 | Capture complete |
| trig_addr_o | output | ADDR_W | Buffer address of trigger sample |

## Verification
Every lane carries a running stamp tagged with its source, so each read-back word shows both the time it was written and the source the multiplexer picked. Captures are driven from each trigger source in turn, while the other sources pulse, to show that only the selected one acts. Early triggers test the history gate. A held trigger level tests edge detection. A long fill with a full-depth record tests that the order survives ring wrap. Repeated captures with no acknowledge separate periodic-mode re-arming from the ack-gated modes.

// File: rtl/wavecap_pkg.sv
package wavecap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    localparam logic [2:0] TRG_TIMER = 3'd0;
    localparam logic [2:0] TRG_ILK   = 3'd1;
    localparam logic [2:0] TRG_EXT0  = 3'd2;
    localparam logic [2:0] TRG_EXT1  = 3'd3;
    localparam logic [2:0] TRG_RAMP  = 3'd4;

    localparam logic [1:0] SRC_ADC = 2'd0;
    localparam logic [1:0] SRC_SUM = 2'd1;
    localparam logic [1:0] SRC_ERR = 2'd2;
    localparam logic [1:0] SRC_DRV = 2'd3;
endpackage

// File: rtl/wavecap_edge.sv
module wavecap_edge #(
    parameter int NUM_IN = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_IN-1:0] sig_i,
    output logic [NUM_IN-1:0] rise_o
);
    logic [NUM_IN-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/wavecap_srcmux.sv
module wavecap_srcmux
    import wavecap_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16
) (
    input  logic [2*NUM_CH-1:0]      sel_i,
    input  logic [NUM_CH*DATA_W-1:0] adc_i,
    input  logic [DATA_W-1:0]        sum_i,
    input  logic [DATA_W-1:0]        err_i,
    input  logic [DATA_W-1:0]        drv_i,
    output logic [NUM_CH*DATA_W-1:0] smp_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            unique case (sel_i[2*c +: 2])
                SRC_ADC: smp_o[c*DATA_W +: DATA_W] = adc_i[c*DATA_W +: DATA_W];
                SRC_SUM: smp_o[c*DATA_W +: DATA_W] = sum_i;
                SRC_ERR: smp_o[c*DATA_W +: DATA_W] = err_i;
                default: smp_o[c*DATA_W +: DATA_W] = drv_i;
            endcase
        end
    end
endmodule

// File: rtl/wavecap_mem.sv
module wavecap_mem #(
    parameter int NUM_CH = 4,
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [NUM_CH*DATA_W-1:0] wr_data_i,
    input  logic [CH_W-1:0]          rd_ch_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [DATA_W-1:0]        rd_data_o
);
    logic [DATA_W-1:0] mem_q [NUM_CH][DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            for (int c = 0; c < NUM_CH; c++) begin
                mem_q[c][wr_addr_i] <= wr_data_i[c*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        rd_d = '0;
        if (int'(rd_ch_i) < NUM_CH) rd_d = mem_q[rd_ch_i][rd_addr_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/wavecap_top.sv
module wavecap_top
    import wavecap_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int DEPTH    = 64,
    parameter int DATA_W   = 16,
    parameter int RATE_CYC = 200,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int TICK_W = $clog2(RATE_CYC)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     arm_i,
    input  logic                     ack_i,
    input  logic [2:0]               trig_sel_i,
    input  logic                     ilk_trip_i,
    input  logic                     ext0_i,
    input  logic                     ext1_i,
    input  logic                     ramp_i,
    input  logic [CNT_W-1:0]         pre_i,
    input  logic [CNT_W-1:0]         post_i,
    input  logic [2*NUM_CH-1:0]      src_sel_i,
    input  logic [NUM_CH*DATA_W-1:0] adc_i,
    input  logic [DATA_W-1:0]        sum_i,
    input  logic [DATA_W-1:0]        err_i,
    input  logic [DATA_W-1:0]        drv_i,
    input  logic [CH_W-1:0]          rd_ch_i,
    input  logic [ADDR_W-1:0]        rd_idx_i,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic                     done_o,
    output logic [ADDR_W-1:0]        trig_addr_o
);
    typedef struct packed {
        cap_state_e        state;
        logic [ADDR_W-1:0] wr_ptr;
        logic [CNT_W-1:0]  fill;
        logic [CNT_W-1:0]  left;
        logic [ADDR_W-1:0] trig_addr;
        logic              done;
        logic [TICK_W-1:0] tick;
    } ctl_t;

    ctl_t d, q;

    logic [3:0]               rise;
    logic [NUM_CH*DATA_W-1:0] smp;
    logic                     wr_en;
    logic                     tick;
    logic                     trig_evt;
    logic                     timer_mode;
    logic [CNT_W-1:0]         post_eff;
    logic [ADDR_W-1:0]        rd_addr;
    logic [CNT_W-1:0]         fill_cnt;
    logic                     post_active;

    wavecap_edge #(.NUM_IN(4)) edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  ({ramp_i, ext1_i, ext0_i, ilk_trip_i}),
        .rise_o (rise)
    );

    wavecap_srcmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) mux_i (
        .sel_i (src_sel_i),
        .adc_i (adc_i),
        .sum_i (sum_i),
        .err_i (err_i),
        .drv_i (drv_i),
        .smp_o (smp)
    );

    always_comb begin
        d          = q;
        wr_en      = 1'b0;
        tick       = (q.tick == TICK_W'(RATE_CYC - 1));
        d.tick     = tick ? '0 : q.tick + 1'b1;
        timer_mode = (trig_sel_i == TRG_TIMER);
        post_eff   = (post_i == '0) ? CNT_W'(1) : post_i;

        unique case (trig_sel_i)
            TRG_TIMER: trig_evt = tick;
            TRG_ILK:   trig_evt = rise[0];
            TRG_EXT0:  trig_evt = rise[1];
            TRG_EXT1:  trig_evt = rise[2];
            TRG_RAMP:  trig_evt = rise[3];
            default:   trig_evt = 1'b0;
        endcase

        unique case (q.state)
            ST_IDLE: begin
                if (arm_i || (timer_mode && tick)) begin
                    d.state  = ST_ARMED;
                    d.wr_ptr = '0;
                    d.fill   = '0;
                end
            end
            ST_ARMED: begin
                wr_en    = 1'b1;
                d.wr_ptr = q.wr_ptr + 1'b1;
                if (q.fill != {CNT_W{1'b1}}) d.fill = q.fill + 1'b1;
                if (trig_evt && (q.fill >= pre_i)) begin
                    d.trig_addr = q.wr_ptr;
                    if (post_eff == CNT_W'(1)) begin
                        d.state = ST_DONE;
                        d.done  = 1'b1;
                    end else begin
                        d.state = ST_POST;
                        d.left  = post_eff - 1'b1;
                    end
                end
            end
            ST_POST: begin
                wr_en    = 1'b1;
                d.wr_ptr = q.wr_ptr + 1'b1;
                d.left   = q.left - 1'b1;
                if (q.left == CNT_W'(1)) begin
                    d.state = ST_DONE;
                    d.done  = 1'b1;
                end
            end
            default: begin
                if (timer_mode) begin
                    if (tick) begin
                        d.state  = ST_ARMED;
                        d.done   = 1'b0;
                        d.wr_ptr = '0;
                        d.fill   = '0;
                    end
                end else if (ack_i) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_addr     = q.trig_addr - pre_i[ADDR_W-1:0] + rd_idx_i;
    assign done_o      = q.done;
    assign trig_addr_o = q.trig_addr;
    assign fill_cnt    = q.fill;
    assign post_active = (q.state == ST_POST);

    wavecap_mem #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .DATA_W(DATA_W)) mem_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_addr_i (q.wr_ptr),
        .wr_data_i (smp),
        .rd_ch_i   (rd_ch_i),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/wavecap_chk.sv
module wavecap_chk #(
    parameter int AW = 6,
    parameter int CW = 7
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          ack_i,
    input logic [2:0]    trig_sel_i,
    input logic          done_o,
    input logic [AW-1:0] trig_addr_o,
    input logic          wr_en,
    input logic          post_active,
    input logic [CW-1:0] fill_cnt,
    input logic [CW-1:0] pre_i
);
    // R9: without ack outside periodic mode, done persists
    assert_done_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !ack_i && trig_sel_i != 3'd0) |=> done_o);

    // R7: latched trigger address does not move while done is held
    assert_trig_addr_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !ack_i && trig_sel_i != 3'd0) |=> $stable(trig_addr_o));

    // R6: buffer is frozen once done
    assert_no_write_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !wr_en);

    // R4: leaving the armed phase needs enough history
    assert_prefill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o || post_active) |-> ($past(fill_cnt) >= $past(pre_i)));
endmodule

bind wavecap_top wavecap_chk #(.AW(ADDR_W), .CW(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_i),
    .trig_sel_i  (trig_sel_i),
    .done_o      (done_o),
    .trig_addr_o (trig_addr_o),
    .wr_en       (wr_en),
    .post_active (post_active),
    .fill_cnt    (fill_cnt),
    .pre_i       (pre_i)
);

// File: tb/wavecap_top_tb_top.sv
`timescale 1ns/1ps
module wavecap_top_tb_top;
    localparam int NCH = 4;
    localparam int DEP = 64;
    localparam int DW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic arm = 0, ack = 0, ilk = 0, ext0 = 0, ext1 = 0, ramp = 0;
    logic [2:0] tsel = 3'd2;
    logic [6:0] pre = 7'd0, post = 7'd1;
    logic [2*NCH-1:0] ssel = '0;
    logic [NCH*DW-1:0] adc;
    logic [DW-1:0] sum, err, drv;
    logic [1:0] rd_ch = 0;
    logic [5:0] rd_idx = 0;
    logic [DW-1:0] rd_data;
    logic done;
    logic [5:0] taddr;

    logic [11:0] stamp = 12'd0;
    always @(posedge clk) stamp <= stamp + 12'd1;

    always_comb begin
        for (int c = 0; c < NCH; c++) adc[c*DW +: DW] = {4'(c), stamp};
        sum = {4'hA, stamp};
        err = {4'hB, stamp};
        drv = {4'hC, stamp};
    end

    wavecap_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .ack_i(ack), .trig_sel_i(tsel),
        .ilk_trip_i(ilk), .ext0_i(ext0), .ext1_i(ext1), .ramp_i(ramp),
        .pre_i(pre), .post_i(post), .src_sel_i(ssel), .adc_i(adc),
        .sum_i(sum), .err_i(err), .drv_i(drv), .rd_ch_i(rd_ch), .rd_idx_i(rd_idx),
        .rd_data_o(rd_data), .done_o(done), .trig_addr_o(taddr)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_arm(output logic [11:0] a);
        arm = 1; a = stamp;
        @(negedge clk); arm = 0;
    endtask

    task automatic do_ack();
        ack = 1;
        @(negedge clk); ack = 0;
    endtask

    task automatic pulse(input int which, output logic [11:0] t);
        t = stamp;
        case (which)
            1: ilk = 1; 2: ext0 = 1; 3: ext1 = 1; default: ramp = 1;
        endcase
        @(negedge clk);
        ilk = 0; ext0 = 0; ext1 = 0; ramp = 0;
    endtask

    task automatic rd(input int ch, input int idx, output logic [DW-1:0] v);
        rd_ch = 2'(ch); rd_idx = 6'(idx);
        @(negedge clk);
        v = rd_data;
    endtask

    function automatic logic [3:0] tag_of(input int ch);
        case (ssel[2*ch +: 2])
            2'd0: return 4'(ch);
            2'd1: return 4'hA;
            2'd2: return 4'hB;
            default: return 4'hC;
        endcase
    endfunction

    task automatic check_rec(input string req, input int np, input int nq, input logic [11:0] t);
        logic [DW-1:0] v, e;
        for (int ch = 0; ch < NCH; ch++) begin
            for (int i = 0; i < np + nq; i++) begin
                rd(ch, i, v);
                e = {tag_of(ch), 12'(t - 12'(np) + 12'(i))};
                chk(v == e, req, $sformatf("ch%0d idx%0d", ch, i), v, e);
            end
        end
    endtask

    // R2 R5 R6 R7 R11: basic external-0 capture with exact timing
    task automatic t_basic();
        logic [11:0] a, t; logic [DW-1:0] v0, v1;
        tsel = 3'd2; pre = 7'd10; post = 7'd6; ssel = '0;
        do_arm(a);
        wait_n(20);
        pulse(2, t);
        wait_n(4);
        chk(done == 1'b0, "R6", "done one cycle early", done, 0);
        wait_n(1);
        chk(done == 1'b1, "R6", "done at post count", done, 1);
        chk(taddr == 6'(t - a - 12'd1), "R7", "trigger address", taddr, 6'(t - a - 12'd1));
        check_rec("R5", 10, 6, t);
        rd(0, 0, v0);
        pulse(2, a);
        wait_n(10);
        rd(0, 0, v1);
        chk(v1 == v0, "R6", "record frozen after done", v1, v0);
        do_ack();
        chk(done == 1'b0, "R9", "ack clears done", done, 0);
    endtask

    // R5: full-depth record after ring wrap
    task automatic t_wrap();
        logic [11:0] a, t;
        tsel = 3'd2; pre = 7'd40; post = 7'd24;
        do_arm(a);
        wait_n(100);
        pulse(2, t);
        wait_n(26);
        chk(done == 1'b1, "R5", "wrap capture done", done, 1);
        check_rec("R5", 40, 24, t);
        do_ack();
    endtask

    // R8: mixed per-channel sources, ramp trigger
    task automatic t_sources();
        logic [11:0] a, t;
        tsel = 3'd4; pre = 7'd4; post = 7'd4;
        ssel = {2'd0, 2'd3, 2'd2, 2'd1};
        do_arm(a);
        wait_n(8);
        pulse(4, t);
        wait_n(5);
        chk(done == 1'b1, "R8", "ramp capture done", done, 1);
        check_rec("R8", 4, 4, t);
        ssel = '0;
        do_ack();
    endtask

    // R2: only the selected source triggers
    task automatic t_select();
        logic [11:0] a, t;
        tsel = 3'd1; pre = 7'd2; post = 7'd2;
        do_arm(a);
        wait_n(5);
        pulse(2, t); wait_n(2);
        pulse(3, t); wait_n(2);
        pulse(4, t); wait_n(6);
        chk(done == 1'b0, "R2", "unselected sources ignored", done, 0);
        pulse(1, t);
        wait_n(2);
        chk(done == 1'b1, "R2", "interlock trip captures", done, 1);
        check_rec("R2", 2, 2, t);
        do_ack();
    endtask

    // R4: early trigger ignored
    task automatic t_prefill();
        logic [11:0] a, t;
        tsel = 3'd2; pre = 7'd20; post = 7'd3;
        do_arm(a);
        wait_n(3);
        pulse(2, t);
        wait_n(10);
        chk(done == 1'b0, "R4", "trigger before history ignored", done, 0);
        wait_n(20);
        pulse(2, t);
        wait_n(3);
        chk(done == 1'b1, "R4", "later trigger accepted", done, 1);
        check_rec("R4", 20, 3, t);
        do_ack();
    endtask

    // R3: held level gives one capture only
    task automatic t_level();
        logic [11:0] a, t; logic [DW-1:0] v;
        tsel = 3'd3; pre = 7'd2; post = 7'd2;
        do_arm(a);
        wait_n(5);
        t = stamp; ext1 = 1;
        wait_n(6);
        chk(done == 1'b1, "R3", "rising edge captures", done, 1);
        rd(0, 2, v);
        chk(v == {4'h0, t}, "R3", "trigger sample", v, {4'h0, t});
        do_ack();
        do_arm(a);
        wait_n(30);
        chk(done == 1'b0, "R3", "held level no recapture", done, 0);
        ext1 = 0;
        wait_n(2);
        pulse(3, t);
        wait_n(3);
        chk(done == 1'b1, "R3", "new edge captures", done, 1);
    endtask

    // R9: arm and trigger ignored while done until ack
    task automatic t_block();
        logic [11:0] a, t; logic [DW-1:0] v0, v1; logic [5:0] ta0;
        rd(0, 0, v0);
        ta0 = taddr;
        do_arm(a);
        wait_n(3);
        pulse(3, t);
        wait_n(5);
        rd(0, 0, v1);
        chk(done == 1'b1, "R9", "done held without ack", done, 1);
        chk(v1 == v0, "R9", "record unchanged", v1, v0);
        chk(taddr == ta0, "R9", "trigger address unchanged", taddr, ta0);
        do_ack();
        chk(done == 1'b0, "R9", "ack returns to idle", done, 0);
    endtask

    // R10: periodic mode repeats without ack
    task automatic t_timer();
        logic [DW-1:0] v0, v;
        bit seen;
        tsel = 3'd0; pre = 7'd8; post = 7'd8;
        seen = 0;
        for (int i = 0; i < 1200 && !seen; i++) begin @(negedge clk); seen = done; end
        chk(seen, "R10", "periodic capture done", seen, 1);
        rd(1, 0, v0);
        for (int i = 1; i < 16; i++) begin
            rd(1, i, v);
            chk(v == {4'h1, 12'(v0[11:0] + 12'(i))}, "R10", $sformatf("contiguous idx%0d", i),
                v, {4'h1, 12'(v0[11:0] + 12'(i))});
        end
        seen = 0;
        for (int i = 0; i < 1200 && !seen; i++) begin @(negedge clk); seen = !done; end
        chk(seen, "R10", "self re-arm clears done", seen, 1);
        seen = 0;
        for (int i = 0; i < 1200 && !seen; i++) begin @(negedge clk); seen = done; end
        chk(seen, "R10", "second capture without ack", seen, 1);
        tsel = 3'd2;
        do_ack();
    endtask

    initial begin
        wait_n(3);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        rst_n = 1;
        wait_n(2);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(taddr == 6'd0, "R1", "trigger address after reset", taddr, 0);
        chk(rd_data == '0, "R1", "read data after reset", rd_data, 0);
        t_basic();
        t_wrap();
        t_sources();
        t_select();
        t_prefill();
        t_level();
        t_block();
        t_timer();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule